// File: doc/BRIEF.md
# Fourteen-bit PWM D/A generator

This block turns a 14-bit code into a pulse train whose mean level, taken over one conversion cycle, is proportional to the code. An external low-pass filter then smooths the pin into an analog voltage. A resolution tick T is derived from the system clock by a selectable power-of-two divider. One conversion cycle lasts 2^14 ticks and is cut into equal base cycles. Every base cycle carries a pulse whose width comes from the upper part of the code. The lower part of the code adds single extra ticks, spread over the base cycles by comparing each bit-reversed base-cycle index against it.

Software loads two registers through a simple write port. One holds the code. The other holds the base-cycle length, the output polarity and the rate code. A new code only takes hold at the next conversion boundary. Clearing the low code bits makes the waveform repeat sooner, which trades precision for a faster-settling output. Small codes give a steady idle level instead of pulses.

Top module: `pwm_dac14`

## Requirements
- R1: The tick T equals 2^(PRESC_LOG2 + 2·c) clock cycles for rate code c in 0..3 (256, 1024, 4096 and 16384 clocks at the default PRESC_LOG2 = 8). The position counter advances by one per tick, and one conversion cycle spans 2^DATA_W ticks.
- R2: With control bit 0 clear, the base cycle is 2^SHORT_W ticks (64 T by default). The top SHORT_W code bits give the pulse width, and the remaining low bits count the base cycles that get one extra tick. Whenever the top SHORT_W bits are nonzero, the active time per conversion is code × T.
- R3: With control bit 0 set, the base cycle is 2^LONG_W ticks (256 T by default) and the code splits at LONG_W upper bits. Whenever those upper bits are nonzero, the active time per conversion is code × T.
- R4: When the upper pulse-width field of the selected mode is zero, the pin stays at the idle level for the whole conversion. By default this covers codes 0x0000 to 0x00FF in the short mode and 0x0000 to 0x003F in the long mode.
- R5: Control bit 1 selects polarity. When it is 0, the idle level is low and pulses are high. When it is 1, both are inverted. A change takes effect on the next clock.
- R6: If the lowest k code bits are zero, with k not above the base-index width of the selected mode, the pin repeats every 2^(DATA_W−k) ticks. By default k = 2 gives 4096 T and k = 4 gives 1024 T.
- R7: Rate codes 4 to 7 (control bits 4:2) are prohibited. While one is selected, the pin holds the idle level and the counters stay cleared.
- R8: While `en` is low, the pin holds the idle level and the counters are cleared. The first conversion starts at the clock edge where `en` is first sampled high.
- R9: A code written during a conversion is not used until the next conversion begins. While the block is disabled, the working copy follows the register.
- R10: After reset, both registers are zero and the pin is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low holds the idle level |
| wr_en | input | 1 | Register write strobe |
| wr_ctrl | input | 1 | 1 selects the control register, 0 the code register |
| wr_wdata | input | DATA_W | Write data; control uses bits 4:0 (rate code 4:2, invert 1, long base 0) |
| pwm_out | output | 1 | PWM output pin |

## Verification
Most internal faults change the number of active ticks in a conversion, so each one appears within a single conversion window of 2^DATA_W ticks. A misplaced extra tick or a wrong split point moves the total away from code × T by a few ticks. A wrong prescaler scales the whole count. A code latched mid-cycle makes the window that holds the write show a total that is neither the old nor the new code. A wrong bit reversal keeps the total intact but breaks the shortened repeat period for codes with cleared low bits, and a comparison of samples one short period apart exposes it within that same conversion.

// File: rtl/pwm_dac14_pkg.sv
package pwm_dac14_pkg;

    localparam int CKS_W     = 3;
    localparam int NUM_RATES = 4;
    localparam int CTRL_W    = 5;

    typedef enum logic {
        BASE_SHORT = 1'b0,
        BASE_LONG  = 1'b1
    } base_e;

    // Field order mirrors the control write layout: rate[4:2], invert[1], base[0]
    typedef struct packed {
        logic [CKS_W-1:0] cks;
        logic             inv;
        base_e            base;
    } ctrl_t;

    function automatic logic rate_ok(input logic [CKS_W-1:0] c);
        return c < CKS_W'(NUM_RATES);
    endfunction

endpackage

// File: rtl/pwm_dac14_regs.sv
module pwm_dac14_regs
    import pwm_dac14_pkg::*;
#(
    parameter int DATA_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_ctrl,
    input  logic [DATA_W-1:0] wr_wdata,
    output logic [DATA_W-1:0] code_reg,
    output ctrl_t             ctrl_reg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            code_reg <= '0;
            ctrl_reg <= '0;
        end else if (wr_en) begin
            if (wr_ctrl) begin
                ctrl_reg <= ctrl_t'(wr_wdata[CTRL_W-1:0]);
            end else begin
                code_reg <= wr_wdata;
            end
        end
    end

endmodule

// File: rtl/pwm_dac14_prescale.sv
module pwm_dac14_prescale
    import pwm_dac14_pkg::*;
#(
    parameter int PRESC_LOG2 = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic [1:0] rate_sel,
    output logic       tick
);

    localparam int MAX_SHIFT = PRESC_LOG2 + 2 * (NUM_RATES - 1);
    localparam int PCNT_W    = MAX_SHIFT + 1;

    logic [PCNT_W-1:0] pcnt;
    logic [PCNT_W-1:0] limit;

    always_comb begin
        limit = (PCNT_W'(1) << (PRESC_LOG2 + 2 * int'(rate_sel))) - PCNT_W'(1);
        tick  = run && (pcnt >= limit);
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pcnt <= '0;
        end else if (tick) begin
            pcnt <= '0;
        end else begin
            pcnt <= pcnt + PCNT_W'(1);
        end
    end

endmodule

// File: rtl/pwm_dac14_seq.sv
module pwm_dac14_seq
    import pwm_dac14_pkg::*;
#(
    parameter int DATA_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              tick,
    input  logic [DATA_W-1:0] code_reg,
    input  base_e             base_reg,
    output logic [DATA_W-1:0] cnt,
    output logic [DATA_W-1:0] code_q,
    output base_e             base_q,
    output logic              wrap
);

    assign wrap = tick && (cnt == '1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            code_q <= '0;
            base_q <= BASE_SHORT;
        end else if (!run) begin
            cnt    <= '0;
            code_q <= code_reg;
            base_q <= base_reg;
        end else if (tick) begin
            cnt <= cnt + DATA_W'(1);
            if (wrap) begin
                code_q <= code_reg;
                base_q <= base_reg;
            end
        end
    end

endmodule

// File: rtl/pwm_dac14_slice.sv
module pwm_dac14_slice #(
    parameter int DATA_W = 14,
    parameter int POS_W  = 6
) (
    input  logic [DATA_W-1:0] cnt,
    input  logic [DATA_W-1:0] code,
    output logic              active
);

    localparam int IDX_W = DATA_W - POS_W;

    logic [POS_W-1:0] pos;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] idx_rev;
    logic [POS_W-1:0] upper;
    logic [IDX_W-1:0] lower;
    logic             extra;
    logic [POS_W:0]   width;

    always_comb begin
        pos   = cnt[POS_W-1:0];
        idx   = cnt[DATA_W-1:POS_W];
        upper = code[DATA_W-1:IDX_W];
        lower = code[IDX_W-1:0];
        for (int b = 0; b < IDX_W; b++) begin
            idx_rev[b] = idx[IDX_W-1-b];
        end
        extra  = idx_rev < lower;
        width  = {1'b0, upper} + (POS_W+1)'(extra);
        active = (upper != '0) && ({1'b0, pos} < width);
    end

endmodule

// File: rtl/pwm_dac14.sv
module pwm_dac14
    import pwm_dac14_pkg::*;
#(
    parameter int DATA_W     = 14,
    parameter int SHORT_W    = 6,
    parameter int LONG_W     = 8,
    parameter int PRESC_LOG2 = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              wr_en,
    input  logic              wr_ctrl,
    input  logic [DATA_W-1:0] wr_wdata,
    output logic              pwm_out
);

    localparam int NUM_MODES = 2;

    logic [DATA_W-1:0]    code_reg;
    ctrl_t                ctrl;
    logic                 run;
    logic                 tick;
    logic                 wrap;
    logic [DATA_W-1:0]    cnt;
    logic [DATA_W-1:0]    code_q;
    base_e                base_q;
    logic [NUM_MODES-1:0] act;
    logic                 act_sel;

    assign run = en && rate_ok(ctrl.cks);

    pwm_dac14_regs #(.DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_ctrl  (wr_ctrl),
        .wr_wdata (wr_wdata),
        .code_reg (code_reg),
        .ctrl_reg (ctrl)
    );

    pwm_dac14_prescale #(.PRESC_LOG2(PRESC_LOG2)) u_presc (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .rate_sel (ctrl.cks[1:0]),
        .tick     (tick)
    );

    pwm_dac14_seq #(.DATA_W(DATA_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .tick     (tick),
        .code_reg (code_reg),
        .base_reg (ctrl.base),
        .cnt      (cnt),
        .code_q   (code_q),
        .base_q   (base_q),
        .wrap     (wrap)
    );

    for (genvar g = 0; g < NUM_MODES; g++) begin : g_mode
        localparam int PW = (g == 0) ? SHORT_W : LONG_W;
        pwm_dac14_slice #(.DATA_W(DATA_W), .POS_W(PW)) u_slice (
            .cnt    (cnt),
            .code   (code_q),
            .active (act[g])
        );
    end

    assign act_sel = (base_q == BASE_LONG) ? act[1] : act[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            pwm_out <= 1'b0;
        end else if (!run) begin
            pwm_out <= ctrl.inv;
        end else begin
            pwm_out <= act_sel ^ ctrl.inv;
        end
    end

endmodule

// File: rtl/pwm_dac14_chk.sv
module pwm_dac14_chk #(
    parameter int DATA_W  = 14,
    parameter int SHORT_W = 6,
    parameter int LONG_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              run,
    input logic              tick,
    input logic              wrap,
    input logic [DATA_W-1:0] cnt,
    input logic [DATA_W-1:0] data_q,
    input logic              base_q,
    input logic              inv,
    input logic [2:0]        cks,
    input logic              pwm_out
);

    logic upper_zero;

    always_comb begin
        if (base_q) begin
            upper_zero = (data_q[DATA_W-1:DATA_W-LONG_W] == '0);
        end else begin
            upper_zero = (data_q[DATA_W-1:DATA_W-SHORT_W] == '0);
        end
    end

    p_step_r1: assert property (@(posedge clk) disable iff (rst)
        (run && tick) |=> (cnt == $past(cnt) + DATA_W'(1)));

    p_hold_cnt_r1: assert property (@(posedge clk) disable iff (rst)
        (run && !tick) |=> $stable(cnt));

    p_const_r4: assert property (@(posedge clk) disable iff (rst)
        (run && upper_zero) |=> (pwm_out == $past(inv)));

    p_bad_rate_r7: assert property (@(posedge clk) disable iff (rst)
        (cks >= 3'd4) |=> (pwm_out == $past(inv)));

    p_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (!run) |=> ((pwm_out == $past(inv)) && (cnt == '0)));

    p_code_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (run && !wrap) |=> ($stable(data_q) && $stable(base_q)));

    p_reset_r10: assert property (@(posedge clk)
        rst |=> (pwm_out == 1'b0));

endmodule

bind pwm_dac14 pwm_dac14_chk #(
    .DATA_W  (DATA_W),
    .SHORT_W (SHORT_W),
    .LONG_W  (LONG_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .tick    (tick),
    .wrap    (wrap),
    .cnt     (cnt),
    .data_q  (code_q),
    .base_q  (base_q),
    .inv     (ctrl.inv),
    .cks     (ctrl.cks),
    .pwm_out (pwm_out)
);

// File: tb/pwm_dac14_test.sv
module pwm_dac14_test;

    localparam int DW    = 7;
    localparam int SW    = 3;
    localparam int LW    = 4;
    localparam int P     = 1 << DW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en = 1'b0;
    logic          wr_en = 1'b0;
    logic          wr_ctrl = 1'b0;
    logic [DW-1:0] wr_wdata = '0;
    logic          pwm_out;

    int checks = 0;
    int errors = 0;
    logic samp [0:P-1];

    always #2 clk = ~clk;

    pwm_dac14 #(.DATA_W(DW), .SHORT_W(SW), .LONG_W(LW), .PRESC_LOG2(0)) uut (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .wr_en    (wr_en),
        .wr_ctrl  (wr_ctrl),
        .wr_wdata (wr_wdata),
        .pwm_out  (pwm_out)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Program control and code while disabled, then raise en; returns at the
    // negedge where en was set, so the next edge starts conversion 0.
    task automatic setup(input int base, input int inv, input int cks, input int code);
        @(negedge clk);
        en = 1'b0; wr_en = 1'b1; wr_ctrl = 1'b1;
        wr_wdata = DW'((cks << 2) | (inv << 1) | base);
        @(negedge clk);
        wr_ctrl = 1'b0; wr_wdata = DW'(code);
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
        en = 1'b1;
    endtask

    task automatic measure(input int n, input logic inv, output int act);
        act = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i < P) samp[i] = pwm_out;
            if (pwm_out !== inv) act++;
        end
    endtask

    initial begin
        int act;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R10 pin after reset", int'(pwm_out), 0);

        // Full sweep: both base modes, both polarities, every code
        for (int base = 0; base < 2; base++) begin
            for (int inv = 0; inv < 2; inv++) begin
                for (int d = 0; d < P; d++) begin
                    int idxw;
                    int expv;
                    int k;
                    int q;
                    int bad;
                    string tag;
                    idxw = (base == 1) ? DW - LW : DW - SW;
                    expv = ((d >> idxw) == 0) ? 0 : d;
                    if ((d >> idxw) == 0) tag = "R4";
                    else if (base == 1) tag = "R3";
                    else tag = "R2";
                    setup(base, inv, 0, d);
                    measure(P, logic'(inv), act);
                    check($sformatf("%s R5 base=%0d inv=%0d code=%0d", tag, base, inv, d), act, expv);
                    k = 0;
                    while (k < idxw && ((d >> k) & 1) == 0) k++;
                    if (k > 0) begin
                        q = P >> k;
                        bad = 0;
                        for (int i = 0; i + q < P; i++) begin
                            if (samp[i] !== samp[i+q]) bad++;
                        end
                        check($sformatf("R6 period %0d base=%0d code=%0d", q, base, d), bad, 0);
                    end
                end
            end
        end

        // R1: slower rate codes scale the active time
        setup(0, 0, 1, 37);  measure(P * 4, 1'b0, act);  check("R1 rate1 code 37", act, 37 * 4);
        setup(0, 0, 1, 127); measure(P * 4, 1'b0, act);  check("R1 rate1 code 127", act, 127 * 4);
        setup(1, 1, 2, 77);  measure(P * 16, 1'b1, act); check("R1 rate2 code 77", act, 77 * 16);
        setup(0, 0, 3, 93);  measure(P * 64, 1'b0, act); check("R1 rate3 code 93", act, 93 * 64);

        // R9: code written mid-conversion waits for the boundary
        setup(0, 0, 0, 100);
        act = 0;
        for (int i = 0; i < P; i++) begin
            @(negedge clk);
            if (pwm_out !== 1'b0) act++;
            if (i == 40) begin wr_en = 1'b1; wr_ctrl = 1'b0; wr_wdata = DW'(50); end
            if (i == 41) wr_en = 1'b0;
        end
        check("R9 conversion of the write keeps old code", act, 100);
        measure(P, 1'b0, act);
        check("R9 next conversion uses new code", act, 50);

        // R8: disable holds idle level
        @(negedge clk);
        en = 1'b0;
        measure(20, 1'b0, act);
        check("R8 disabled pin idle", act, 0);

        // R7: prohibited rate code holds idle level, inverted polarity
        setup(0, 1, 5, 100);
        measure(64, 1'b1, act);
        check("R7 prohibited rate idle", act, 0);
        @(negedge clk);
        wr_en = 1'b1; wr_ctrl = 1'b1; wr_wdata = DW'((0 << 2) | (1 << 1) | 0);
        @(negedge clk);
        wr_en = 1'b0;
        measure(P, 1'b1, act);
        check("R7 valid rate resumes from cycle start", act, 100);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R8 watchdog actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule